// File: doc/BRIEF.md
# TLB Maintenance Command Decoder

This block sits on the write port of a system register file. It watches every register write. When the address falls on one of the translation-cache maintenance slots, it turns the write into a one-cycle invalidate command for the instruction TLB, the data TLB, or both. It also stops that write from reaching the register storage. Every other write passes through to the register file unchanged.

Each command carries a 2-bit operation code and a page address and an ASID, both taken from the write data. The operation is one of: invalidate everything, invalidate one page for one ASID, invalidate all pages of one ASID, or invalidate one page under every ASID. Fields that an operation does not use are driven as zero. The maintenance slots form a window of sixteen addresses starting at the parameter `MAINT_BASE`. Within that window, the offset gives both the operation and the TLBs it is aimed at. The TLBs themselves lie outside this block; only their command interfaces are produced here.

Top module: `tlb_maint_decoder`

## Requirements
- R1: For a write at offset `off = wr_addr - MAINT_BASE`, bits `off[3:2]` select the operation, and that value appears on the op outputs: 0 = invalidate all, 1 = by page and ASID, 2 = by ASID, 3 = by page under any ASID.
- R2: Offsets whose `off[1:0]` is 0 (unified) or 1 (inner-shareable) pulse both `itlb_vld` and `dtlb_vld`.
- R3: An offset with `off[1:0]` = 2 pulses only `itlb_vld`, and one with `off[1:0]` = 3 pulses only `dtlb_vld`.
- R4: Offsets 14 and 15, and every address outside the 16-slot window, are ordinary registers. They raise no command, and `rf_wr_en` equals `wr_en` for them in the same cycle.
- R5: A write to a maintenance slot (offsets 0 to 13) holds `rf_wr_en` low in that cycle, so nothing is stored.
- R6: Each accepted maintenance write produces exactly one valid pulse, lasting one cycle, in the cycle after the write. Writes on consecutive cycles produce pulses on consecutive cycles.
- R7: The by-page-and-ASID operation carries `wr_data[31:12]` as the page address and `wr_data[7:0]` as the ASID.
- R8: The by-ASID operation carries `wr_data[7:0]` as the ASID and a page address of zero.
- R9: The by-page-any-ASID operation carries `wr_data[31:12]` as the page address and an ASID of zero.
- R10: The invalidate-all operation carries a zero page address and a zero ASID.
- R11: After reset, and in any cycle that follows a cycle with no maintenance write, both valid outputs are low.
- R12: When both TLBs receive a command in the same cycle, their op, page address and ASID outputs are identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rf_wr_en | output | 1 | Write strobe forwarded to register storage |
| itlb_vld | output | 1 | Instruction TLB command valid |
| itlb_op | output | 2 | Instruction TLB operation code |
| itlb_va | output | DATA_W-VA_LSB | Instruction TLB page address |
| itlb_asid | output | ASID_W | Instruction TLB ASID |
| dtlb_vld | output | 1 | Data TLB command valid |
| dtlb_op | output | 2 | Data TLB operation code |
| dtlb_va | output | DATA_W-VA_LSB | Data TLB page address |
| dtlb_asid | output | ASID_W | Data TLB ASID |

## Verification
Two kinds of activity can fall in the same cycle:
- A fresh maintenance write arrives while the previous write's command pulse is still on the outputs.
- An ordinary write is forwarded to storage while a command is being issued.

Directed back-to-back maintenance writes provoke the first case. Writes with a random mix of enables and addresses, biased into the window, provoke both cases. The bench keeps one pending expected command per cycle. It compares both valid lines, the fields and `rf_wr_en` in the cycles where each should change. A lost, merged or stretched pulse therefore shows up as a mismatch in a named check.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

  typedef enum logic [1:0] {
    OP_ALL     = 2'd0,
    OP_VA_ASID = 2'd1,
    OP_ASID    = 2'd2,
    OP_VA_ANY  = 2'd3
  } tlbm_op_e;

  typedef enum logic [1:0] {
    VAR_UNI  = 2'd0,
    VAR_ISH  = 2'd1,
    VAR_INST = 2'd2,
    VAR_DATA = 2'd3
  } tlbm_var_e;

  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_I    = 0;
  localparam int unsigned PORT_D    = 1;
  localparam int unsigned NUM_OPS   = 4;
  localparam int unsigned NUM_VARS  = 4;
  localparam int unsigned SLOT_W    = $clog2(NUM_OPS * NUM_VARS);

  function automatic logic [NUM_PORTS-1:0] var_targets(tlbm_var_e v);
    logic [NUM_PORTS-1:0] t;
    t = '0;
    case (v)
      VAR_UNI, VAR_ISH: t = '1;
      VAR_INST:         t[PORT_I] = 1'b1;
      VAR_DATA:         t[PORT_D] = 1'b1;
      default:          t = '0;
    endcase
    return t;
  endfunction

  function automatic logic op_has_va(tlbm_op_e op);
    return (op == OP_VA_ASID) || (op == OP_VA_ANY);
  endfunction

  function automatic logic op_has_asid(tlbm_op_e op);
    return (op == OP_VA_ASID) || (op == OP_ASID);
  endfunction

endpackage

// File: rtl/tlbm_rst_sync.sv
module tlbm_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/tlbm_addr_decode.sv
module tlbm_addr_decode
  import tlbm_pkg::*;
#(
  parameter int unsigned          ADDR_W     = 8,
  parameter logic [ADDR_W-1:0]    MAINT_BASE = 8'h40
) (
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  output logic                 maint_sel,
  output logic                 hit,
  output tlbm_op_e             op,
  output logic [NUM_PORTS-1:0] targets
);

  localparam int unsigned HI_W = ADDR_W - SLOT_W;

  logic [ADDR_W-1:0] offset;
  logic              in_window;
  tlbm_var_e         variant;
  logic              slot_legal;

  always_comb begin
    offset    = wr_addr - MAINT_BASE;
    in_window = (offset[ADDR_W-1:SLOT_W] == {HI_W{1'b0}});
    op        = tlbm_op_e'(offset[SLOT_W-1:2]);
    variant   = tlbm_var_e'(offset[1:0]);
    // the page-any-ASID operation has no split-side variants
    slot_legal = !((op == OP_VA_ANY) &&
                   ((variant == VAR_INST) || (variant == VAR_DATA)));
    maint_sel = in_window && slot_legal;
    hit       = wr_en && maint_sel;
    targets   = hit ? var_targets(variant) : '0;
  end

endmodule

// File: rtl/tlbm_field_extract.sv
module tlbm_field_extract
  import tlbm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned VA_LSB = 12,
  parameter int unsigned ASID_W = 8,
  localparam int unsigned VA_W  = DATA_W - VA_LSB
) (
  input  logic [DATA_W-1:0] data,
  input  tlbm_op_e          op,
  output logic [VA_W-1:0]   va,
  output logic [ASID_W-1:0] asid
);

  logic unused_mid_bits;

  always_comb begin
    va   = op_has_va(op)   ? data[DATA_W-1:VA_LSB] : '0;
    asid = op_has_asid(op) ? data[ASID_W-1:0]      : '0;
  end

  assign unused_mid_bits = ^data;

endmodule

// File: rtl/tlbm_cmd_reg.sv
module tlbm_cmd_reg
  import tlbm_pkg::*;
#(
  parameter int unsigned VA_W   = 20,
  parameter int unsigned ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  tlbm_op_e          op_in,
  input  logic [VA_W-1:0]   va_in,
  input  logic [ASID_W-1:0] asid_in,
  output logic              vld_q,
  output tlbm_op_e          op_q,
  output logic [VA_W-1:0]   va_q,
  output logic [ASID_W-1:0] asid_q
);

  logic              vld_d;
  logic              load_en;
  tlbm_op_e          op_d;
  logic [VA_W-1:0]   va_d;
  logic [ASID_W-1:0] asid_d;

  always_comb begin
    vld_d   = fire;
    load_en = fire;
    op_d    = op_in;
    va_d    = va_in;
    asid_d  = asid_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      op_q   <= OP_ALL;
      va_q   <= '0;
      asid_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (load_en) begin
        op_q   <= op_d;
        va_q   <= va_d;
        asid_q <= asid_d;
      end
    end
  end

endmodule

// File: rtl/tlb_maint_decoder.sv
module tlb_maint_decoder
  import tlbm_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 8,
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       VA_LSB     = 12,
  parameter int unsigned       ASID_W     = 8,
  parameter logic [ADDR_W-1:0] MAINT_BASE = 8'h40,
  localparam int unsigned      VA_W       = DATA_W - VA_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rf_wr_en,
  output logic              itlb_vld,
  output logic [1:0]        itlb_op,
  output logic [VA_W-1:0]   itlb_va,
  output logic [ASID_W-1:0] itlb_asid,
  output logic              dtlb_vld,
  output logic [1:0]        dtlb_op,
  output logic [VA_W-1:0]   dtlb_va,
  output logic [ASID_W-1:0] dtlb_asid
);

  logic                 core_rst_n;
  logic                 maint_sel;
  logic                 hit;
  tlbm_op_e             dec_op;
  logic [NUM_PORTS-1:0] targets;
  logic [VA_W-1:0]      ext_va;
  logic [ASID_W-1:0]    ext_asid;

  logic [NUM_PORTS-1:0] port_vld;
  tlbm_op_e             port_op   [NUM_PORTS];
  logic [VA_W-1:0]      port_va   [NUM_PORTS];
  logic [ASID_W-1:0]    port_asid [NUM_PORTS];

  tlbm_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (core_rst_n)
  );

  tlbm_addr_decode #(
    .ADDR_W     (ADDR_W),
    .MAINT_BASE (MAINT_BASE)
  ) u_decode (
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .maint_sel (maint_sel),
    .hit       (hit),
    .op        (dec_op),
    .targets   (targets)
  );

  tlbm_field_extract #(
    .DATA_W (DATA_W),
    .VA_LSB (VA_LSB),
    .ASID_W (ASID_W)
  ) u_extract (
    .data (wr_data),
    .op   (dec_op),
    .va   (ext_va),
    .asid (ext_asid)
  );

  generate
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
      tlbm_cmd_reg #(
        .VA_W   (VA_W),
        .ASID_W (ASID_W)
      ) u_cmd (
        .clk     (clk),
        .rst_n   (core_rst_n),
        .fire    (targets[g]),
        .op_in   (dec_op),
        .va_in   (ext_va),
        .asid_in (ext_asid),
        .vld_q   (port_vld[g]),
        .op_q    (port_op[g]),
        .va_q    (port_va[g]),
        .asid_q  (port_asid[g])
      );
    end
  endgenerate

  // maintenance writes never reach storage
  assign rf_wr_en  = wr_en && !maint_sel;

  assign itlb_vld  = port_vld[PORT_I];
  assign itlb_op   = port_op[PORT_I];
  assign itlb_va   = port_va[PORT_I];
  assign itlb_asid = port_asid[PORT_I];

  assign dtlb_vld  = port_vld[PORT_D];
  assign dtlb_op   = port_op[PORT_D];
  assign dtlb_va   = port_va[PORT_D];
  assign dtlb_asid = port_asid[PORT_D];

  logic unused_hit;
  assign unused_hit = hit;

endmodule

// File: rtl/tlbm_chk.sv
module tlbm_chk #(
  parameter int unsigned       ADDR_W     = 8,
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       VA_LSB     = 12,
  parameter int unsigned       ASID_W     = 8,
  parameter logic [ADDR_W-1:0] MAINT_BASE = 8'h40,
  localparam int unsigned      VA_W       = DATA_W - VA_LSB
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rf_wr_en,
  input logic              itlb_vld,
  input logic [1:0]        itlb_op,
  input logic [VA_W-1:0]   itlb_va,
  input logic [ASID_W-1:0] itlb_asid,
  input logic              dtlb_vld,
  input logic [1:0]        dtlb_op,
  input logic [VA_W-1:0]   dtlb_va,
  input logic [ASID_W-1:0] dtlb_asid
);

  logic [ADDR_W-1:0] off;
  logic              is_maint;

  assign off      = wr_addr - MAINT_BASE;
  assign is_maint = (off < 14);

  // R5
  maint_not_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_maint) |-> !rf_wr_en);

  // R4
  plain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_maint) |-> rf_wr_en);

  // R11
  no_cmd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && is_maint) |=> (!itlb_vld && !dtlb_vld));

  // R6
  cmd_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_maint) |=> (itlb_vld || dtlb_vld));

  // R3
  inst_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_maint && off[1:0] == 2'd2) |=> (itlb_vld && !dtlb_vld));

  // R3
  data_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_maint && off[1:0] == 2'd3) |=> (!itlb_vld && dtlb_vld));

  // R12
  same_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (itlb_vld && dtlb_vld) |->
      (itlb_op == dtlb_op && itlb_va == dtlb_va && itlb_asid == dtlb_asid));

  // R7
  va_asid_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_maint && off[3:2] == 2'd1) |=>
      ((itlb_vld || dtlb_vld) &&
       (itlb_vld ? (itlb_va == $past(wr_data[DATA_W-1:VA_LSB]) &&
                    itlb_asid == $past(wr_data[ASID_W-1:0]))
                 : (dtlb_va == $past(wr_data[DATA_W-1:VA_LSB]) &&
                    dtlb_asid == $past(wr_data[ASID_W-1:0])))));

  // R8
  asid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (itlb_vld && itlb_op == 2'd2) |-> (itlb_va == '0));

  // R9
  va_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dtlb_vld && dtlb_op == 2'd3) |-> (dtlb_asid == '0));

  // R10
  all_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dtlb_vld && dtlb_op == 2'd0) |-> (dtlb_va == '0 && dtlb_asid == '0));

endmodule

bind tlb_maint_decoder tlbm_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .VA_LSB     (VA_LSB),
  .ASID_W     (ASID_W),
  .MAINT_BASE (MAINT_BASE)
) u_tlbm_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rf_wr_en  (rf_wr_en),
  .itlb_vld  (itlb_vld),
  .itlb_op   (itlb_op),
  .itlb_va   (itlb_va),
  .itlb_asid (itlb_asid),
  .dtlb_vld  (dtlb_vld),
  .dtlb_op   (dtlb_op),
  .dtlb_va   (dtlb_va),
  .dtlb_asid (dtlb_asid)
);

// File: tb/test_tlb_maint_decoder.sv
`timescale 1ns/1ps
module test_tlb_maint_decoder;

  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned VA_LSB = 12;
  localparam int unsigned ASID_W = 8;
  localparam int unsigned VA_W   = DATA_W - VA_LSB;
  localparam logic [ADDR_W-1:0] BASE = 8'h40;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              rf_wr_en;
  logic              itlb_vld, dtlb_vld;
  logic [1:0]        itlb_op, dtlb_op;
  logic [VA_W-1:0]   itlb_va, dtlb_va;
  logic [ASID_W-1:0] itlb_asid, dtlb_asid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // pending expectation for the next cycle
  logic              p_i, p_d, p_prev_cmd;
  logic [1:0]        p_op;
  logic [VA_W-1:0]   p_va;
  logic [ASID_W-1:0] p_asid;

  tlb_maint_decoder #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .VA_LSB (VA_LSB),
    .ASID_W (ASID_W), .MAINT_BASE (BASE)
  ) i_tlb_maint_decoder (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .rf_wr_en (rf_wr_en),
    .itlb_vld (itlb_vld), .itlb_op (itlb_op), .itlb_va (itlb_va),
    .itlb_asid (itlb_asid),
    .dtlb_vld (dtlb_vld), .dtlb_op (dtlb_op), .dtlb_va (dtlb_va),
    .dtlb_asid (dtlb_asid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [ADDR_W-1:0] offs(logic [ADDR_W-1:0] a);
    return a - BASE;
  endfunction
  function automatic logic e_maint(logic [ADDR_W-1:0] a);
    return offs(a) < 14;
  endfunction
  function automatic logic [VA_W-1:0] e_va(logic [1:0] op, logic [DATA_W-1:0] d);
    return (op == 2'd1 || op == 2'd3) ? d[DATA_W-1:VA_LSB] : '0;
  endfunction
  function automatic logic [ASID_W-1:0] e_asid(logic [1:0] op, logic [DATA_W-1:0] d);
    return (op == 2'd1 || op == 2'd2) ? d[ASID_W-1:0] : '0;
  endfunction

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string fld_tag(logic [1:0] op);
    case (op)
      2'd0:    return "R10";
      2'd1:    return "R7";
      2'd2:    return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check_outputs();
    string vt;
    if (p_i && p_d)      vt = "R2";
    else if (p_i || p_d) vt = "R3";
    else if (p_prev_cmd) vt = "R6";
    else                 vt = "R11";
    chk(itlb_vld == p_i, {vt, " itlb_vld"}, itlb_vld, p_i);
    chk(dtlb_vld == p_d, {vt, " dtlb_vld"}, dtlb_vld, p_d);
    if (p_i) begin
      chk(itlb_op == p_op, "R1 itlb_op", itlb_op, p_op);
      chk(itlb_va == p_va, {fld_tag(p_op), " itlb_va"}, itlb_va, p_va);
      chk(itlb_asid == p_asid, {fld_tag(p_op), " itlb_asid"}, itlb_asid, p_asid);
    end
    if (p_d) begin
      chk(dtlb_op == p_op, "R1 dtlb_op", dtlb_op, p_op);
      chk(dtlb_va == p_va, {fld_tag(p_op), " dtlb_va"}, dtlb_va, p_va);
      chk(dtlb_asid == p_asid, {fld_tag(p_op), " dtlb_asid"}, dtlb_asid, p_asid);
    end
    if (p_i && p_d) begin
      chk({itlb_op, itlb_va, itlb_asid} == {dtlb_op, dtlb_va, dtlb_asid},
          "R12 payload match", {itlb_op, itlb_asid}, {dtlb_op, dtlb_asid});
    end
  endtask

  task automatic step(input logic we, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d);
    logic [ADDR_W-1:0] o;
    logic m;
    check_outputs();
    wr_en = we; wr_addr = a; wr_data = d;
    #0.5;
    o = offs(a);
    m = e_maint(a);
    if (we && m) chk(rf_wr_en == 1'b0, "R5 rf_wr_en", rf_wr_en, 1'b0);
    else         chk(rf_wr_en == we, "R4 rf_wr_en", rf_wr_en, we);
    p_prev_cmd = p_i || p_d;
    p_i    = we && m && (o[1:0] != 2'd3);
    p_d    = we && m && (o[1:0] != 2'd2);
    p_op   = o[3:2];
    p_va   = e_va(o[3:2], d);
    p_asid = e_asid(o[3:2], d);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R6 watchdog expired: actual %0d expected %0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    p_i = 0; p_d = 0; p_prev_cmd = 0; p_op = 0; p_va = '0; p_asid = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(itlb_vld == 1'b0, "R11 reset itlb_vld", itlb_vld, 0);
    chk(dtlb_vld == 1'b0, "R11 reset dtlb_vld", dtlb_vld, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // every slot of the window plus neighbours, idle between
    for (int k = -1; k < 17; k++) begin
      step(1'b1, BASE + ADDR_W'(k), 32'hA5C3_7F00 ^ (32'(k) * 32'h0101_1111));
      step(1'b0, BASE + ADDR_W'(k), 32'h0);
    end
    // back-to-back maintenance writes (R6)
    for (int k = 0; k < 14; k++) begin
      step(1'b1, BASE + ADDR_W'(k), {20'(k + 1), 4'hF, 8'(8'hE0 + k)});
    end
    // maintenance write then plain write in the next cycle
    step(1'b1, BASE + 8'd4, 32'hFFFF_F0AB);
    step(1'b1, BASE + 8'd20, 32'h1234_5678);
    step(1'b1, BASE + 8'd15, 32'hDEAD_BEEF);
    step(1'b1, BASE + 8'd12, 32'hCAFE_F0CC);
    step(1'b0, 8'h00, 32'h0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic we;
      logic [ADDR_W-1:0] a;
      we = ($urandom % 4) != 0;
      a  = (($urandom % 4) == 0) ? ADDR_W'($urandom) : BASE + ADDR_W'($urandom % 16);
      step(we, a, $urandom);
    end
    step(1'b0, 8'h00, 32'h0);
    step(1'b0, 8'h00, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule